// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits beside a small processor core and decides, once per clock, whether an interrupt is taken. It weighs a non-maskable interrupt pin against a set of maskable sources. Each source carries a 4-bit priority level and a cause code. The decision uses the core's status word: a block flag, a mode flag, a register-bank flag and a 4-bit mask. It also uses a sleep indication and two control bits. The first control bit makes a low NMI pin shut out every maskable source. The second lets an NMI through even while the block flag is set.

When an interrupt is taken, the unit stores the status word and the current program counter in shadow registers. It writes the cause code into two event-code registers and raises a one-cycle branch request. In the same cycle it hands the core an updated status word with the block, mode and bank flags set. If the core was asleep, a one-cycle wake pulse goes out alongside the branch request.

Maskable requests pass through a registered settling pipeline before the accept decision sees them. Software therefore has to wait a few cycles after clearing a source flag before it clears the block flag.

Top module: `intr_accept`

## Requirements
- R1: After reset, `branch_req`, `wake_out` and `stat_upd_en` are 0, and `ssr_out`, `spc_out`, `evt_code_out` and `evt_code2_out` are all zero.
- R2: Among pending maskable sources, the one with the highest level wins. On equal levels the lowest source index wins. A source with level 0 is never selected.
- R3: A maskable winner of level N is taken only when the status mask (`stat_in[3:0]`) is N-1 or less.
- R4: A maskable request is taken only when the block flag (`stat_in[6]`) is 0 or `sleep_in` is 1.
- R5: While `mask_all_en` is 1 and `nmi_pin` is low, no maskable request is taken.
- R6: A falling edge on `nmi_pin` latches a pending NMI. The NMI outranks every maskable level and ignores the mask. It is taken while the block flag is 0, or `sleep_in` is 1, or `nmi_thru_bl` is 1; otherwise it stays pending. Its cause code is the parameter `NMI_CODE` (default 12'h1C0).
- R7: On acceptance, `ssr_out` takes the status word and `spc_out` takes `pc_in` from the deciding cycle. `evt_code_out` and `evt_code2_out` both take the winner's cause code.
- R8: `stat_upd_en` pulses together with `branch_req`. `stat_upd_val` equals the saved status with bits 6, 5 and 4 (block, mode, bank) forced to 1.
- R9: A maskable request that first appears before rising edge k raises `branch_req` after edge k+SETTLE (SETTLE defaults to 2). An NMI edge seen before edge k raises it after edge k+1. A source cleared fewer than SETTLE+1 edges before the block flag is cleared can still be taken once more.
- R10: `wake_out` is 1 for exactly the cycle of `branch_req` when `sleep_in` was 1 at the decision, and 0 otherwise.
- R11: `branch_req` lasts one cycle. No second acceptance is decided during the branch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_pin | input | 1 | Non-maskable interrupt pin level |
| src_pend | input | NSRC | Pending flag of each maskable source |
| src_lvl | input | NSRC*4 | Priority level of each source, source i at [4i+3:4i] |
| src_code | input | NSRC*CODE_W | Cause code of each source |
| stat_in | input | 7 | Core status: [6] block, [5] mode, [4] bank, [3:0] mask |
| pc_in | input | PC_W | Current program counter |
| sleep_in | input | 1 | Core is in sleep mode |
| mask_all_en | input | 1 | A low NMI pin blocks all maskable sources |
| nmi_thru_bl | input | 1 | NMI accepted while the block flag is set |
| branch_req | output | 1 | One-cycle request to branch to the handler |
| wake_out | output | 1 | One-cycle wake pulse for a sleeping core |
| stat_upd_en | output | 1 | Load `stat_upd_val` into the core status |
| stat_upd_val | output | 7 | New status word with entry flags set |
| ssr_out | output | 7 | Saved status word |
| spc_out | output | PC_W | Saved program counter |
| evt_code_out | output | CODE_W | First event-code register |
| evt_code2_out | output | CODE_W | Second event-code register |

## Verification
The saved status, the saved PC and both event codes are registered only when an interrupt is taken. If the winner selection or the settling pipeline holds a wrong entry, it shows up at the ports in one of three ways: the wrong cause code, a branch in the wrong cycle, or a branch that should not have happened. Each appears on the edge after the stale entry reaches the last pipeline stage, at most SETTLE+1 edges after the input change. A lost or stuck NMI latch shows up as a missing or repeated NMI branch one edge after the gating opens. The bench models the acceptance rule cycle by cycle. It compares every output on every clock, so a one-cycle timing error is caught at once.

// File: rtl/intr_accept_pkg.sv
`timescale 1ns/1ps
package intr_accept_pkg;
   localparam int ST_W  = 7;
   localparam int ST_BL = 6;
   localparam int ST_MD = 5;
   localparam int ST_RB = 4;
   localparam int LVL_W = 4;
   localparam int MAX_SRC = 15;

   localparam logic [ST_W-1:0] ENTRY_BITS =
      ST_W'((1 << ST_BL) | (1 << ST_MD) | (1 << ST_RB));

   function automatic logic [ST_W-1:0] entry_status(input logic [ST_W-1:0] s);
      return s | ENTRY_BITS;
   endfunction
endpackage

// File: rtl/intr_prio_arb.sv
`timescale 1ns/1ps
module intr_prio_arb
   import intr_accept_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int CODE_W = 12
) (
   input  logic [NSRC-1:0]        pend,
   input  logic [NSRC*LVL_W-1:0]  lvl,
   input  logic [NSRC*CODE_W-1:0] code,
   output logic                   win_vld,
   output logic [LVL_W-1:0]       win_lvl,
   output logic [CODE_W-1:0]      win_code
);
   always_comb begin
      win_vld  = 1'b0;
      win_lvl  = '0;
      win_code = '0;
      for (int i = 0; i < NSRC; i++) begin
         // strict compare: an equal level never displaces a lower index
         if (pend[i] && (lvl[i*LVL_W +: LVL_W] > win_lvl)) begin
            win_vld  = 1'b1;
            win_lvl  = lvl[i*LVL_W +: LVL_W];
            win_code = code[i*CODE_W +: CODE_W];
         end
      end
   end
endmodule

// File: rtl/intr_settle_pipe.sv
`timescale 1ns/1ps
module intr_settle_pipe #(
   parameter int W      = 17,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CW = STAGES * W;

   logic [CW-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CW-W-1:0], d};
         end
      end
   endgenerate

   assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/intr_nmi_sense.sv
`timescale 1ns/1ps
module intr_nmi_sense #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic clr,
   output logic pend
);
   localparam logic IDLE_LVL = FALL_EDGE;

   logic pin_q;
   logic edge_seen;

   generate
      if (FALL_EDGE) begin : g_fall
         assign edge_seen = pin_q & ~pin;
      end else begin : g_rise
         assign edge_seen = ~pin_q & pin;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= IDLE_LVL;
         pend  <= 1'b0;
      end else begin
         pin_q <= pin;
         if (edge_seen)  pend <= 1'b1;
         else if (clr)   pend <= 1'b0;
      end
   end
endmodule

// File: rtl/intr_accept.sv
`timescale 1ns/1ps
module intr_accept
   import intr_accept_pkg::*;
#(
   parameter int              NSRC     = 4,
   parameter int              CODE_W   = 12,
   parameter int              PC_W     = 32,
   parameter int              SETTLE   = 2,
   parameter logic [11:0]     NMI_CODE = 12'h1C0,
   parameter bit              NMI_FALL = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   nmi_pin,
   input  logic [NSRC-1:0]        src_pend,
   input  logic [NSRC*4-1:0]      src_lvl,
   input  logic [NSRC*CODE_W-1:0] src_code,
   input  logic [6:0]             stat_in,
   input  logic [PC_W-1:0]        pc_in,
   input  logic                   sleep_in,
   input  logic                   mask_all_en,
   input  logic                   nmi_thru_bl,
   output logic                   branch_req,
   output logic                   wake_out,
   output logic                   stat_upd_en,
   output logic [6:0]             stat_upd_val,
   output logic [6:0]             ssr_out,
   output logic [PC_W-1:0]        spc_out,
   output logic [CODE_W-1:0]      evt_code_out,
   output logic [CODE_W-1:0]      evt_code2_out
);
   localparam int PW = 1 + LVL_W + CODE_W;
   localparam logic [CODE_W-1:0] NMI_EVT = CODE_W'(NMI_CODE);

   generate
      if (NSRC < 1 || NSRC > MAX_SRC) begin : g_bad_nsrc
         $error("intr_accept: NSRC must lie in 1..15");
      end
      if (SETTLE < 1) begin : g_bad_settle
         $error("intr_accept: SETTLE must be at least 1");
      end
      if (CODE_W < 1 || PC_W < 1) begin : g_bad_width
         $error("intr_accept: widths must be positive");
      end
   endgenerate

   // winner selection
   logic              arb_vld;
   logic [LVL_W-1:0]  arb_lvl;
   logic [CODE_W-1:0] arb_code;

   intr_prio_arb #(.NSRC(NSRC), .CODE_W(CODE_W)) u_arb (
      .pend     (src_pend),
      .lvl      (src_lvl),
      .code     (src_code),
      .win_vld  (arb_vld),
      .win_lvl  (arb_lvl),
      .win_code (arb_code)
   );

   // settling pipeline
   logic [PW-1:0]     cand_q;
   logic              cand_vld;
   logic [LVL_W-1:0]  cand_lvl;
   logic [CODE_W-1:0] cand_code;

   intr_settle_pipe #(.W(PW), .STAGES(SETTLE)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({arb_vld, arb_lvl, arb_code}),
      .q     (cand_q)
   );
   assign {cand_vld, cand_lvl, cand_code} = cand_q;

   // NMI capture
   logic nmi_pend;
   logic nmi_take;

   intr_nmi_sense #(.FALL_EDGE(NMI_FALL)) u_nmi (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (nmi_pin),
      .clr   (nmi_take),
      .pend  (nmi_pend)
   );

   // accept decision
   logic              branch_q;
   logic              wake_q;
   logic              acc_nmi_q;
   logic              gate_open;
   logic              all_masked;
   logic              mk_take;
   logic              take;
   logic [CODE_W-1:0] take_code;
   logic [6:0]        ssr_q;
   logic [PC_W-1:0]   spc_q;
   logic [CODE_W-1:0] evt_q;
   logic [CODE_W-1:0] evt2_q;

   always_comb begin
      gate_open  = !stat_in[ST_BL] || sleep_in;
      all_masked = mask_all_en && !nmi_pin;
      nmi_take   = nmi_pend && (gate_open || nmi_thru_bl) && !branch_q;
      mk_take    = cand_vld && (cand_lvl > stat_in[3:0]) && gate_open &&
                   !all_masked && !nmi_take && !branch_q;
      take       = nmi_take || mk_take;
      take_code  = nmi_take ? NMI_EVT : cand_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         branch_q  <= 1'b0;
         wake_q    <= 1'b0;
         acc_nmi_q <= 1'b0;
      end else begin
         branch_q  <= take;
         wake_q    <= take && sleep_in;
         acc_nmi_q <= nmi_take;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ssr_q  <= '0;
         spc_q  <= '0;
         evt_q  <= '0;
         evt2_q <= '0;
      end else if (take) begin
         ssr_q  <= stat_in;
         spc_q  <= pc_in;
         evt_q  <= take_code;
         evt2_q <= take_code;
      end
   end

   assign branch_req    = branch_q;
   assign wake_out      = wake_q;
   assign stat_upd_en   = branch_q;
   assign stat_upd_val  = entry_status(ssr_q);
   assign ssr_out       = ssr_q;
   assign spc_out       = spc_q;
   assign evt_code_out  = evt_q;
   assign evt_code2_out = evt2_q;
endmodule

// File: rtl/intr_accept_chk.sv
`timescale 1ns/1ps
module intr_accept_chk #(
   parameter int PC_W   = 32,
   parameter int CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              nmi_pin,
   input logic [6:0]        stat_in,
   input logic [PC_W-1:0]   pc_in,
   input logic              sleep_in,
   input logic              mask_all_en,
   input logic              nmi_thru_bl,
   input logic              branch_req,
   input logic              wake_out,
   input logic [6:0]        ssr_out,
   input logic [PC_W-1:0]   spc_out,
   input logic [CODE_W-1:0] evt_code_out,
   input logic [CODE_W-1:0] evt_code2_out,
   input logic              acc_nmi_q,
   input logic [3:0]        cand_lvl
);
   assert_branch_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      branch_req |=> !branch_req);

   assert_wake_in_branch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_out |-> branch_req);

   assert_wake_from_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_out |-> $past(sleep_in));

   assert_save_context_R7: assert property (@(posedge clk) disable iff (!rst_n)
      branch_req |-> (spc_out == $past(pc_in)) && (ssr_out == $past(stat_in)));

   assert_evt_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      branch_req |-> evt_code_out == evt_code2_out);

   assert_block_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (branch_req && !acc_nmi_q) |-> (!$past(stat_in[6]) || $past(sleep_in)));

   assert_nmi_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (branch_req && acc_nmi_q) |->
         (!$past(stat_in[6]) || $past(sleep_in) || $past(nmi_thru_bl)));

   assert_mask_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (branch_req && !acc_nmi_q) |-> ($past(cand_lvl) > $past(stat_in[3:0])));

   assert_mask_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (branch_req && !acc_nmi_q) |-> !($past(mask_all_en) && !$past(nmi_pin)));
endmodule

bind intr_accept intr_accept_chk #(.PC_W(PC_W), .CODE_W(CODE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .nmi_pin       (nmi_pin),
   .stat_in       (stat_in),
   .pc_in         (pc_in),
   .sleep_in      (sleep_in),
   .mask_all_en   (mask_all_en),
   .nmi_thru_bl   (nmi_thru_bl),
   .branch_req    (branch_req),
   .wake_out      (wake_out),
   .ssr_out       (ssr_out),
   .spc_out       (spc_out),
   .evt_code_out  (evt_code_out),
   .evt_code2_out (evt_code2_out),
   .acc_nmi_q     (acc_nmi_q),
   .cand_lvl      (cand_lvl)
);

// File: tb/intr_accept_tb.sv
`timescale 1ns/1ps
module intr_accept_tb;
   localparam int NSRC = 4, CODE_W = 12, PC_W = 32, SETTLE = 2;
   localparam logic [11:0] NMI_C = 12'h1C0;

   logic clk = 1'b0, rst_n = 1'b0;
   logic nmi_pin = 1'b1;
   logic [NSRC-1:0] src_pend = '0;
   logic [3:0] lv [NSRC];
   logic [NSRC*4-1:0] src_lvl;
   logic [NSRC*CODE_W-1:0] src_code;
   logic [6:0] stat_in = '0;
   logic [PC_W-1:0] pc_in = 32'h1000;
   logic sleep_in = 1'b0, mask_all_en = 1'b0, nmi_thru_bl = 1'b0;
   logic branch_req, wake_out, stat_upd_en;
   logic [6:0] stat_upd_val, ssr_out;
   logic [PC_W-1:0] spc_out;
   logic [CODE_W-1:0] evt_code_out, evt_code2_out;

   int checks = 0, fails = 0, cycles = 0;

   always #2.5 clk = ~clk;

   function automatic logic [11:0] code_of(input int i);
      return 12'h400 + 12'(i * 32);
   endfunction

   always_comb begin
      for (int i = 0; i < NSRC; i++) begin
         src_lvl[i*4 +: 4]        = lv[i];
         src_code[i*CODE_W +: CODE_W] = code_of(i);
      end
   end

   intr_accept #(.NSRC(NSRC), .CODE_W(CODE_W), .PC_W(PC_W), .SETTLE(SETTLE),
                 .NMI_CODE(NMI_C)) u_dut (
      .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .src_pend(src_pend),
      .src_lvl(src_lvl), .src_code(src_code), .stat_in(stat_in), .pc_in(pc_in),
      .sleep_in(sleep_in), .mask_all_en(mask_all_en), .nmi_thru_bl(nmi_thru_bl),
      .branch_req(branch_req), .wake_out(wake_out), .stat_upd_en(stat_upd_en),
      .stat_upd_val(stat_upd_val), .ssr_out(ssr_out), .spc_out(spc_out),
      .evt_code_out(evt_code_out), .evt_code2_out(evt_code2_out));

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // ---------------- reference model ----------------
   bit          hv [$];
   int          hl [$];
   int          hc [$];
   bit          m_branch, m_wake, m_flag, m_prev;
   logic [6:0]  m_ssr;
   logic [31:0] m_spc;
   int          m_evt;

   always @(posedge clk) begin
      bit cv; int cl, cc, bl_lvl, bc; bit bvld, gate, nt, mt, fall;
      if (!rst_n) begin
         hv.delete(); hl.delete(); hc.delete();
         for (int s = 0; s < SETTLE; s++) begin hv.push_back(0); hl.push_back(0); hc.push_back(0); end
         m_branch = 0; m_wake = 0; m_flag = 0; m_prev = 1;
         m_ssr = 0; m_spc = 0; m_evt = 0;
      end else begin
         cv = hv.pop_front(); cl = hl.pop_front(); cc = hc.pop_front();
         bvld = 0; bl_lvl = 0; bc = 0;
         for (int i = 0; i < NSRC; i++)
            if (src_pend[i] && int'(lv[i]) > bl_lvl) begin bvld = 1; bl_lvl = lv[i]; bc = code_of(i); end
         hv.push_back(bvld); hl.push_back(bl_lvl); hc.push_back(bc);
         gate = !stat_in[6] || sleep_in;
         nt = m_flag && (gate || nmi_thru_bl) && !m_branch;
         mt = cv && (cl > int'(stat_in[3:0])) && gate && !(mask_all_en && !nmi_pin) && !nt && !m_branch;
         if (nt || mt) begin
            m_ssr = stat_in; m_spc = pc_in; m_evt = nt ? int'(NMI_C) : cc;
         end
         m_wake = (nt || mt) && sleep_in;
         m_branch = nt || mt;
         fall = m_prev && !nmi_pin;
         if (fall) m_flag = 1; else if (nt) m_flag = 0;
         m_prev = nmi_pin;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R11 branch_req", branch_req, m_branch);
         chk("R10 wake_out", wake_out, m_wake);
         chk("R8 stat_upd_en", stat_upd_en, m_branch);
         chk("R8 stat_upd_val", stat_upd_val, m_ssr | 7'h70);
         chk("R7 ssr_out", ssr_out, m_ssr);
         chk("R7 spc_out", spc_out, m_spc);
         chk("R2 evt_code_out", evt_code_out, m_evt);
         chk("R7 evt_code2_out", evt_code2_out, m_evt);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc();
      @(negedge clk);
      pc_in = pc_in + 4;
      if (m_branch) stat_in = m_ssr | 7'h70;   // core applies the entry status
   endtask

   task automatic wait_br(input int maxc, output int n);
      n = 0;
      for (int k = 0; k < maxc; k++) begin
         cyc(); n++;
         if (branch_req) return;
      end
      n = -1;
   endtask

   task automatic count_br(input int len, output int cnt);
      cnt = 0;
      for (int k = 0; k < len; k++) begin cyc(); if (branch_req) cnt++; end
   endtask

   task automatic settle_ret(input logic [6:0] s);
      for (int k = 0; k < 4; k++) cyc();
      stat_in = s;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 20000) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int n, cnt;
      for (int i = 0; i < NSRC; i++) lv[i] = 4'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 branch", branch_req, 0);
      chk("R1 evt", evt_code_out, 0);
      chk("R1 ssr", ssr_out, 0);
      chk("R1 upd_en", stat_upd_en, 0);

      // basic acceptance and latency
      lv[1] = 4'd5; src_pend = 4'b0010;
      wait_br(10, n);
      chk("R9 latency maskable", n, SETTLE + 1);
      chk("R7 evt code", evt_code_out, code_of(1));
      chk("R7 ssr saved", ssr_out, 7'h00);
      chk("R8 new status", stat_upd_val, 7'h70);
      src_pend = '0;
      cyc();
      chk("R11 single pulse", branch_req, 0);
      settle_ret(7'h00);

      // R2 priority and tie break
      lv[0] = 4'd3; lv[2] = 4'd9; lv[3] = 4'd9; src_pend = 4'b1101;
      wait_br(10, n);
      chk("R2 highest level lowest index", evt_code_out, code_of(2));
      src_pend[2] = 1'b0; settle_ret(7'h00);
      wait_br(10, n);
      chk("R2 next tie winner", evt_code_out, code_of(3));
      src_pend[3] = 1'b0; settle_ret(7'h00);
      wait_br(10, n);
      chk("R2 lowest level last", evt_code_out, code_of(0));
      src_pend = '0; settle_ret(7'h00);

      // R3 mask compare
      lv[1] = 4'd9; src_pend = 4'b0010; stat_in = 7'h09;
      count_br(6, cnt);
      chk("R3 level equal to mask blocked", cnt, 0);
      stat_in = 7'h08;
      wait_br(10, n);
      chk("R3 level above mask taken", evt_code_out, code_of(1));
      chk("R3 ssr keeps mask", ssr_out, 7'h08);
      src_pend = '0; settle_ret(7'h00);

      // R4 block flag and sleep, R10 wake
      lv[2] = 4'd15; src_pend = 4'b0100; stat_in = 7'h40;
      count_br(6, cnt);
      chk("R4 block flag holds level 15", cnt, 0);
      sleep_in = 1'b1;
      wait_br(10, n);
      chk("R10 wake with branch", wake_out, 1);
      chk("R4 taken in sleep", evt_code_out, code_of(2));
      sleep_in = 1'b0; src_pend = '0;
      cyc();
      chk("R10 wake one cycle", wake_out, 0);
      settle_ret(7'h00);

      // R6 NMI beats level 15 in the same decision
      lv[3] = 4'd15; src_pend = 4'b1000;
      cyc();
      nmi_pin = 1'b0;
      wait_br(10, n);
      chk("R9 latency nmi", n, 2);
      chk("R6 nmi outranks level 15", evt_code_out, NMI_C);
      // R5 mask-all with NMI low
      mask_all_en = 1'b1;
      settle_ret(7'h00);
      count_br(6, cnt);
      chk("R5 mask-all blocks maskable", cnt, 0);
      mask_all_en = 1'b0;
      wait_br(10, n);
      chk("R5 released after mask-all off", evt_code_out, code_of(3));
      src_pend = '0; nmi_pin = 1'b1; settle_ret(7'h00);

      // R6 NMI waits on block flag, then passes with through bit
      stat_in = 7'h4F; nmi_pin = 1'b0;
      count_br(6, cnt);
      chk("R6 nmi held by block flag", cnt, 0);
      stat_in = 7'h0F;
      wait_br(10, n);
      chk("R6 pending nmi taken, mask ignored", evt_code_out, NMI_C);
      nmi_pin = 1'b1; settle_ret(7'h40);
      nmi_thru_bl = 1'b1;
      cyc();
      nmi_pin = 1'b0;
      wait_br(10, n);
      chk("R6 nmi through block flag", n, 2);
      chk("R6 ssr shows block set", ssr_out, 7'h40);
      nmi_thru_bl = 1'b0; nmi_pin = 1'b1; settle_ret(7'h00);

      // R9 stale request after an early return
      lv[1] = 4'd6; src_pend = 4'b0010;
      wait_br(10, n);
      cyc();
      src_pend = '0; stat_in = 7'h00;
      count_br(6, cnt);
      chk("R9 early return sees old request", cnt, 1);
      settle_ret(7'h00);
      src_pend = 4'b0010;
      wait_br(10, n);
      cyc();
      src_pend = '0;
      repeat (3) cyc();
      stat_in = 7'h00;
      count_br(6, cnt);
      chk("R9 late return sees nothing", cnt, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule